// File: doc/BRIEF.md
# Key-Locked Flash Command Front End

This block is the register-side front end of an embedded flash controller. Software reaches it over a small 32-bit register bus with three words: a key word, a status word and a control word. After reset the control word is locked. It opens only when two fixed 32-bit keys are written to the key word in the right order. Once the control word is open, software can pick a program width, a sector number and an operation type, then launch a sector erase, a mass erase or a single program operation.

A program operation starts when a data write reaches the flash window while the program enable is set. Every launched operation holds a busy flag for a fixed number of cycles. That counter takes the place of the real array timing. Any request the block rejects raises a sticky error flag instead, and no operation starts. Each sector has a write-protect input. An erase or program aimed at a protected sector is refused.

Top module: `flash_ctl_front`

Bus word index (`bus_addr`): 0 is the key word, 1 is the status word, 2 is the control word. Reading the key word returns zero.

## Requirements
- R1: After reset, `busy` is 0. The control word reads 0x8000_0000, meaning only the lock bit (bit 31) is set. The status word reads 0.
- R2: A write of 0x4567_0123 to the key word, followed by a write of 0xCDEF_89AB, clears the lock bit. Other bus writes may come in between.
- R3: If the key word receives a wrong value, or the keys arrive in the wrong order, the block stays locked until the next reset, even if the correct pair follows later. While the block is locked, control writes leave the control word unchanged.
- R4: While the block is open and idle, a control write with bit 31 set locks it again and leaves the other fields unchanged. A later correct key pair opens it again.
- R5: A sector erase starts on a control write that has bit 1 (sector erase), the sector number in bits 6:3 and bit 16 (start) set together. `busy` is then high for exactly SER_CYC cycles.
- R6: A mass erase starts on a control write with bit 2 (or bit 15) and bit 16 set. `busy` is then high for exactly MER_CYC cycles. The start bit reads back as 0.
- R7: When bit 0 (program) is set, a flash-window write starts one program operation if its access width code equals the width field in bits 9:8 (0=8, 1=16, 2=32, 3=64 bit) and its address is aligned to that width. `busy` is then high for exactly PROG_CYC cycles.
- R8: A flash-window write whose width code differs from bits 9:8 sets status bit 6 and starts nothing.
- R9: A flash-window write whose address is misaligned for the selected width sets status bit 5 and starts nothing.
- R10: Status bit 7 is set, and nothing else changes, in these cases: a flash-window write while bit 0 is clear or the block is locked; a flash-window write while busy; a control write while open and busy.
- R11: The sector of a program address is taken from its top 4 bits. A program or sector erase aimed at a protected sector, or a mass erase while any sector is protected, sets status bit 4 and starts nothing.
- R12: Status error bits 7, 6, 5, 4 and 1 are sticky. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. Status bit 16 mirrors `busy`.
- R13: A start request with no erase type selected sets status bit 1 and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| fw_we | input | 1 | Flash-window data write strobe |
| fw_addr | input | ADDR_W | Flash-window byte address |
| fw_size | input | 2 | Access width code of the window write |
| wp_sector | input | 2**SNB_W | Per-sector write-protect |
| busy | output | 1 | Operation in progress |

## Verification
A key sequencer stuck in the wrong state is visible on the very next read of the control word, through the lock bit. A control field latched when it should have been ignored also reads back wrongly on the next read. A wrong command decode shows either as a `busy` pulse of the wrong length or at the wrong time, or as a missing or extra sticky status bit, one cycle after the offending write. A faulty clear path leaves a status bit set, or drops one, on the read right after a status write that carries a 0 or a 1 in that position.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

  localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
  localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;

  // register word indices
  localparam logic [1:0] RA_KEY  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;

  // control word bit positions
  localparam int CB_PROG  = 0;
  localparam int CB_SERA  = 1;
  localparam int CB_MERA  = 2;
  localparam int CB_SNB   = 3;
  localparam int CB_WID   = 8;
  localparam int CB_MERB  = 15;
  localparam int CB_GO    = 16;
  localparam int CB_LOCK  = 31;

  // status word bit positions
  localparam int SB_BUSY  = 16;
  localparam int SB_SEQ   = 7;
  localparam int SB_PAR   = 6;
  localparam int SB_ALN   = 5;
  localparam int SB_WRP   = 4;
  localparam int SB_OPE   = 1;

  // internal error vector order
  localparam int EI_SEQ = 4;
  localparam int EI_PAR = 3;
  localparam int EI_ALN = 2;
  localparam int EI_WRP = 1;
  localparam int EI_OPE = 0;
  localparam int ERR_N  = 5;

  typedef enum logic [1:0] {
    KS_WAIT_A,
    KS_WAIT_B,
    KS_OPEN,
    KS_DEAD
  } key_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_PROG,
    OP_SERASE,
    OP_MERASE
  } op_kind_e;

endpackage

// File: rtl/flash_key_lock.sv
module flash_key_lock
  import flash_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_val,
  input  logic        relock,
  output logic        locked
);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_WAIT_A: if (key_we) state_d = (key_val == KEY_FIRST)  ? KS_WAIT_B : KS_DEAD;
      KS_WAIT_B: if (key_we) state_d = (key_val == KEY_SECOND) ? KS_OPEN   : KS_DEAD;
      KS_OPEN:   if (relock) state_d = KS_WAIT_A;
      KS_DEAD:   state_d = KS_DEAD;
      default:   state_d = KS_DEAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_WAIT_A;
    else        state_q <= state_d;
  end

  assign locked = (state_q != KS_OPEN);

endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
  import flash_ctl_pkg::*;
#(
  parameter int PROG_CYC = 4,
  parameter int SER_CYC  = 12,
  parameter int MER_CYC  = 20
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_e kind,
  output logic     busy
);

  localparam int MAX_A  = (PROG_CYC > SER_CYC) ? PROG_CYC : SER_CYC;
  localparam int MAX_C  = (MAX_A > MER_CYC) ? MAX_A : MER_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      cnt_en = 1'b1;
      unique case (kind)
        OP_PROG:   cnt_d = CNT_W'(PROG_CYC);
        OP_SERASE: cnt_d = CNT_W'(SER_CYC);
        OP_MERASE: cnt_d = CNT_W'(MER_CYC);
        default:   cnt_d = '0;
      endcase
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/flash_err_flags.sv
module flash_err_flags
  import flash_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] set_vec,
  input  logic             clr_we,
  input  logic [ERR_N-1:0] clr_mask,
  output logic [ERR_N-1:0] err_q
);

  logic [ERR_N-1:0] err_d;
  logic             err_en;

  always_comb begin
    err_d  = err_q;
    if (clr_we) err_d = err_d & ~clr_mask;
    err_d  = err_d | set_vec;
    err_en = clr_we | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

endmodule

// File: rtl/flash_ctl_front.sv
module flash_ctl_front
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SNB_W    = 4,
  parameter int PROG_CYC = 4,
  parameter int SER_CYC  = 12,
  parameter int MER_CYC  = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [1:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic                  fw_we,
  input  logic [ADDR_W-1:0]     fw_addr,
  input  logic [1:0]            fw_size,
  input  logic [(1<<SNB_W)-1:0] wp_sector,
  output logic                  busy
);

  localparam int NSECT = 1 << SNB_W;

  logic             locked;
  logic             sel_key, sel_stat, sel_ctrl;
  logic             relock, ctrl_wr_ok, ctrl_busy;
  logic             prog_q, sera_q, mera_q, merb_q;
  logic [SNB_W-1:0] snb_q;
  logic [1:0]       wid_q;
  logic             ctl_start, fw_start, op_start;
  op_kind_e         ctl_kind, op_kind;
  logic [ERR_N-1:0] ctl_err, fw_err, err_set, err_q, clr_mask;
  logic             n_sera, n_mer;
  logic [SNB_W-1:0] n_snb;
  logic             fw_misal;
  logic [SNB_W-1:0] fw_sect;
  logic [31:0]      ctrl_view, stat_view;

  // register decode
  always_comb begin
    sel_key    = bus_we && (bus_addr == RA_KEY);
    sel_stat   = bus_we && (bus_addr == RA_STAT);
    sel_ctrl   = bus_we && (bus_addr == RA_CTRL);
    ctrl_busy  = sel_ctrl && !locked && busy;
    relock     = sel_ctrl && !locked && !busy && bus_wdata[CB_LOCK];
    ctrl_wr_ok = sel_ctrl && !locked && !busy && !bus_wdata[CB_LOCK];
    n_sera     = bus_wdata[CB_SERA];
    n_mer      = bus_wdata[CB_MERA] | bus_wdata[CB_MERB];
    n_snb      = bus_wdata[CB_SNB +: SNB_W];
  end

  flash_key_lock u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .key_we (sel_key),
    .key_val(bus_wdata),
    .relock (relock),
    .locked (locked)
  );

  // control word fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b0;
      sera_q <= 1'b0;
      mera_q <= 1'b0;
      merb_q <= 1'b0;
      snb_q  <= '0;
      wid_q  <= '0;
    end else if (ctrl_wr_ok) begin
      prog_q <= bus_wdata[CB_PROG];
      sera_q <= bus_wdata[CB_SERA];
      mera_q <= bus_wdata[CB_MERA];
      merb_q <= bus_wdata[CB_MERB];
      snb_q  <= n_snb;
      wid_q  <= bus_wdata[CB_WID +: 2];
    end
  end

  // erase launch decode
  always_comb begin
    ctl_start = 1'b0;
    ctl_kind  = OP_NONE;
    ctl_err   = '0;
    if (ctrl_busy) begin
      ctl_err[EI_SEQ] = 1'b1;
    end else if (ctrl_wr_ok && bus_wdata[CB_GO]) begin
      if (n_sera && n_mer) begin
        ctl_err[EI_SEQ] = 1'b1;
      end else if (n_sera) begin
        if (wp_sector[n_snb]) ctl_err[EI_WRP] = 1'b1;
        else begin
          ctl_start = 1'b1;
          ctl_kind  = OP_SERASE;
        end
      end else if (n_mer) begin
        if (|wp_sector) ctl_err[EI_WRP] = 1'b1;
        else begin
          ctl_start = 1'b1;
          ctl_kind  = OP_MERASE;
        end
      end else begin
        ctl_err[EI_OPE] = 1'b1;
      end
    end
  end

  // program launch decode
  always_comb begin
    unique case (wid_q)
      2'd0:    fw_misal = 1'b0;
      2'd1:    fw_misal = fw_addr[0];
      2'd2:    fw_misal = |fw_addr[1:0];
      default: fw_misal = |fw_addr[2:0];
    endcase
    fw_sect  = fw_addr[ADDR_W-1 -: SNB_W];
    fw_start = 1'b0;
    fw_err   = '0;
    if (fw_we) begin
      if (busy || ctl_start || locked || !prog_q) begin
        fw_err[EI_SEQ] = 1'b1;
      end else begin
        fw_err[EI_PAR] = (fw_size != wid_q);
        fw_err[EI_ALN] = fw_misal;
        fw_err[EI_WRP] = wp_sector[fw_sect];
        fw_start       = !(fw_err[EI_PAR] | fw_err[EI_ALN] | fw_err[EI_WRP]);
      end
    end
  end

  always_comb begin
    op_start = ctl_start | fw_start;
    op_kind  = ctl_start ? ctl_kind : (fw_start ? OP_PROG : OP_NONE);
    err_set  = ctl_err | fw_err;
    clr_mask = '0;
    clr_mask[EI_SEQ] = bus_wdata[SB_SEQ];
    clr_mask[EI_PAR] = bus_wdata[SB_PAR];
    clr_mask[EI_ALN] = bus_wdata[SB_ALN];
    clr_mask[EI_WRP] = bus_wdata[SB_WRP];
    clr_mask[EI_OPE] = bus_wdata[SB_OPE];
  end

  flash_busy_timer #(
    .PROG_CYC(PROG_CYC),
    .SER_CYC (SER_CYC),
    .MER_CYC (MER_CYC)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(op_start),
    .kind (op_kind),
    .busy (busy)
  );

  flash_err_flags u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (err_set),
    .clr_we  (sel_stat),
    .clr_mask(clr_mask),
    .err_q   (err_q)
  );

  // read views
  always_comb begin
    ctrl_view                   = '0;
    ctrl_view[CB_LOCK]          = locked;
    ctrl_view[CB_MERB]          = merb_q;
    ctrl_view[CB_WID +: 2]      = wid_q;
    ctrl_view[CB_SNB +: SNB_W]  = snb_q;
    ctrl_view[CB_MERA]          = mera_q;
    ctrl_view[CB_SERA]          = sera_q;
    ctrl_view[CB_PROG]          = prog_q;
    stat_view                   = '0;
    stat_view[SB_BUSY]          = busy;
    stat_view[SB_SEQ]           = err_q[EI_SEQ];
    stat_view[SB_PAR]           = err_q[EI_PAR];
    stat_view[SB_ALN]           = err_q[EI_ALN];
    stat_view[SB_WRP]           = err_q[EI_WRP];
    stat_view[SB_OPE]           = err_q[EI_OPE];
    unique case (bus_addr)
      RA_STAT: bus_rdata = stat_view;
      RA_CTRL: bus_rdata = ctrl_view;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/flash_ctl_front_chk.sv
module flash_ctl_front_chk #(
  parameter int ADDR_W = 16,
  parameter int SNB_W  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_we,
  input logic [1:0]            bus_addr,
  input logic [31:0]           bus_wdata,
  input logic                  fw_we,
  input logic [ADDR_W-1:0]     fw_addr,
  input logic [(1<<SNB_W)-1:0] wp_sector,
  input logic                  busy,
  input logic                  locked,
  input logic [4:0]            err_q,
  input logic [31:0]           ctrl_view
);

  // R2
  unlock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bus_we && bus_addr == 2'd0 && bus_wdata == 32'hCDEF_89AB));

  // R3
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2 && locked) |=> $stable(ctrl_view));

  // R10
  busy_cmd_seqerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2 && busy && !locked) |=> err_q[4]);

  // R11
  wp_blocks_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_we && !busy && !(bus_we && bus_addr == 2'd2) &&
     wp_sector[fw_addr[ADDR_W-1 -: SNB_W]]) |=> !busy);

  // R12
  err_clear_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err_q) & ~err_q)) |-> $past(bus_we && bus_addr == 2'd1));

  // R7
  busy_needs_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fw_we || (bus_we && bus_addr == 2'd2)));

endmodule

bind flash_ctl_front flash_ctl_front_chk #(
  .ADDR_W(ADDR_W),
  .SNB_W (SNB_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .fw_we    (fw_we),
  .fw_addr  (fw_addr),
  .wp_sector(wp_sector),
  .busy     (busy),
  .locked   (locked),
  .err_q    (err_q),
  .ctrl_view(ctrl_view)
);

// File: tb/flash_ctl_front_tb.sv
`timescale 1ns/1ps
module flash_ctl_front_tb;

  localparam int ADDR_W = 16;
  localparam int SNB_W  = 4;
  localparam int PROG_C = 4;
  localparam int SER_C  = 12;
  localparam int MER_C  = 20;

  logic              clk;
  logic              rst_n;
  logic              bus_we;
  logic [1:0]        bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              fw_we;
  logic [ADDR_W-1:0] fw_addr;
  logic [1:0]        fw_size;
  logic [15:0]       wp_sector;
  logic              busy;

  int checks;
  int errors;
  bit done;

  flash_ctl_front #(
    .ADDR_W(ADDR_W), .SNB_W(SNB_W),
    .PROG_CYC(PROG_C), .SER_CYC(SER_C), .MER_CYC(MER_C)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fw_we(fw_we),
    .fw_addr(fw_addr), .fw_size(fw_size), .wp_sector(wp_sector), .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic fwr(logic [ADDR_W-1:0] a, logic [1:0] s);
    @(negedge clk);
    fw_we = 1'b1; fw_addr = a; fw_size = s;
    @(negedge clk);
    fw_we = 1'b0;
  endtask

  function automatic logic [31:0] rd(logic [1:0] a);
    bus_addr = a;
    return bus_rdata;
  endfunction

  task automatic rdchk(string req, logic [1:0] a, logic [31:0] exp);
    bus_addr = a;
    #0.1;
    check(req, bus_rdata, exp);
  endtask

  task automatic busy_len(string req, int exp);
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(req, 32'(n), 32'(exp));
  endtask

  task automatic unlock();
    wr(2'd0, 32'h4567_0123);
    wr(2'd0, 32'hCDEF_89AB);
  endtask

  task automatic t_reset();
    do_reset();
    rdchk("R1 ctrl", 2'd2, 32'h8000_0000);
    rdchk("R1 stat", 2'd1, 32'h0);
    check("R1 busy", 32'(busy), 32'h0);
  endtask

  task automatic t_locked_ignore();
    wr(2'd2, 32'h0000_0101);
    rdchk("R3 locked ctrl write ignored", 2'd2, 32'h8000_0000);
  endtask

  task automatic t_unlock();
    unlock();
    rdchk("R2 unlocked", 2'd2, 32'h0);
    wr(2'd2, 32'h0000_0101);
    rdchk("R2 fields written", 2'd2, 32'h0000_0101);
  endtask

  task automatic t_program();
    fwr(16'h0010, 2'd1);
    busy_len("R7 program busy length", PROG_C);
    rdchk("R7 no error", 2'd1, 32'h0);
  endtask

  task automatic t_par();
    fwr(16'h0020, 2'd2);
    check("R8 no busy", 32'(busy), 32'h0);
    rdchk("R8 par bit", 2'd1, 32'h40);
    wr(2'd1, 32'h0000_0000);
    rdchk("R12 zero write keeps", 2'd1, 32'h40);
    wr(2'd1, 32'h0000_0040);
    rdchk("R12 one write clears", 2'd1, 32'h0);
  endtask

  task automatic t_align();
    fwr(16'h0021, 2'd1);
    check("R9 no busy", 32'(busy), 32'h0);
    rdchk("R9 align bit", 2'd1, 32'h20);
    wr(2'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_wrp();
    wp_sector = 16'h0008;
    fwr(16'h3000, 2'd1);
    check("R11 prog blocked", 32'(busy), 32'h0);
    rdchk("R11 wrp bit prog", 2'd1, 32'h10);
    wr(2'd1, 32'h10);
    wr(2'd2, 32'h0001_001A);
    check("R11 erase blocked", 32'(busy), 32'h0);
    rdchk("R11 wrp bit erase", 2'd1, 32'h10);
    wr(2'd1, 32'h10);
    wr(2'd2, 32'h0001_0004);
    rdchk("R11 mass erase blocked", 2'd1, 32'h10);
    wr(2'd1, 32'h10);
    wp_sector = '0;
  endtask

  task automatic t_sector_erase();
    wr(2'd2, 32'h0001_002A);
    busy_len("R5 sector erase busy length", SER_C);
    rdchk("R5 ctrl readback", 2'd2, 32'h0000_002A);
  endtask

  task automatic t_busy_cmd();
    wr(2'd2, 32'h0001_002A);
    wr(2'd2, 32'h0000_0001);
    rdchk("R10 busy ctrl write ignored", 2'd2, 32'h0000_002A);
    rdchk("R10 seq bit while busy", 2'd1, 32'h0001_0080);
    busy_len("R10 busy unchanged", SER_C - 2);
    wr(2'd1, 32'h80);
  endtask

  task automatic t_seq_nopg();
    wr(2'd2, 32'h0);
    fwr(16'h0000, 2'd0);
    check("R10 no busy", 32'(busy), 32'h0);
    rdchk("R10 seq bit no pg", 2'd1, 32'h80);
    wr(2'd1, 32'h80);
  endtask

  task automatic t_mass();
    wr(2'd2, 32'h0000_0004);
    wr(2'd2, 32'h0001_0004);
    busy_len("R6 mass erase busy length", MER_C);
    rdchk("R6 go bit reads 0", 2'd2, 32'h0000_0004);
  endtask

  task automatic t_operr();
    wr(2'd2, 32'h0001_0000);
    check("R13 no busy", 32'(busy), 32'h0);
    rdchk("R13 op bit", 2'd1, 32'h02);
    wr(2'd1, 32'h02);
    rdchk("R12 op cleared", 2'd1, 32'h0);
  endtask

  task automatic t_relock();
    wr(2'd2, 32'h0000_0101);
    wr(2'd2, 32'h8000_0000);
    rdchk("R4 relocked", 2'd2, 32'h8000_0101);
    unlock();
    rdchk("R4 reopened", 2'd2, 32'h0000_0101);
  endtask

  task automatic t_bad_key();
    wr(2'd2, 32'h8000_0000);
    wr(2'd0, 32'hCDEF_89AB);
    unlock();
    rdchk("R3 wrong order stays locked", 2'd2, 32'h8000_0101);
    wr(2'd2, 32'h0000_0002);
    rdchk("R3 dead ctrl write ignored", 2'd2, 32'h8000_0101);
    do_reset();
    wr(2'd0, 32'h1234_5678);
    wr(2'd0, 32'hCDEF_89AB);
    rdchk("R3 wrong value stays locked", 2'd2, 32'h8000_0000);
    do_reset();
    unlock();
    rdchk("R3 reset restores unlock", 2'd2, 32'h0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    fw_we = 0; fw_addr = 0; fw_size = 0; wp_sector = 0;
    rst_n = 1'b0;
    t_reset();
    t_locked_ignore();
    t_unlock();
    t_program();
    t_par();
    t_align();
    t_wrp();
    t_sector_erase();
    t_busy_cmd();
    t_seq_nopg();
    t_mass();
    t_operr();
    t_relock();
    t_bad_key();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule